// File: doc/BRIEF.md
# Modulo Timer with Center-Aligned Counting

This block is a 16-bit timebase that software configures over a small byte-wide register bus. A clock-select field either stops the timer or picks one of three count sources: every bus clock cycle, or one of two external enables. Each external enable is a one-cycle pulse that is already synchronous to the bus clock. A power-of-two prescaler sits after the source selection and sets how often the counter steps. The counter runs against a programmable modulo limit. In up mode it wraps from the limit to zero. In center-aligned mode it climbs to the limit, turns around and falls back to zero, which gives the symmetric period that centered PWM channels need.

Every period end sets a sticky overflow flag. Software clears that flag with a two-step sequence: it first reads the status while the flag is set, then writes 0 to the flag bit. An overflow that arrives between those two steps cancels the pending clear. An enable bit routes the flag to an interrupt output. The counter is read as two bytes. Reading the high byte captures the low byte, so software can reassemble a 16-bit value taken at one instant.

The overflow flag is a three-state machine. FLAG_CLEAR moves to FLAG_SET on an overflow. FLAG_SET moves to FLAG_ARMED when the status is read and no overflow occurs in that cycle. FLAG_ARMED moves to FLAG_CLEAR when 0 is written to the flag bit. From FLAG_SET or FLAG_ARMED an overflow always leads back to FLAG_SET. The count direction is a two-state machine. DIR_UP moves to DIR_DOWN when the counter meets the limit in center-aligned mode. DIR_DOWN moves to DIR_UP when the counter reaches zero. Clearing the counter, or leaving center-aligned mode, forces DIR_UP.

Top module: `modtimer_core`

## Requirements
- R1: After reset, every register reads 0. This puts the timer in up mode with its clock stopped, and the counter stays at 0 however many cycles pass.
- R2: The clock-select field is control bits 4:3. Code 0 stops counting, code 1 counts every bus cycle, code 2 counts `ext_tick_a` pulses and code 3 counts `ext_tick_b` pulses. The source that is not selected has no effect.
- R3: The prescale field is control bits 7:5. A code p makes the counter advance once per 2^p selected source events.
- R4: In up mode (control bit 2 = 0) a step taken while the counter equals the limit loads 0 and sets the overflow flag (control bit 0). Any other step adds 1.
- R5: A modulo of 0 makes the limit 0xFFFF, so the counter runs through the full 16-bit range and overflows when it goes from 0xFFFF to 0.
- R6: In center-aligned mode (control bit 2 = 1) the counter rises to the limit and then falls to 0 and rises again. The flag sets on the step from the limit to the limit minus 1, and not when the counter reaches 0.
- R7: Writing 0 to control bit 0 clears the flag only if the status was read while the flag was set, and no later overflow has occurred. Writing 1 to that bit, or writing 0 without the prior read, leaves the flag set.
- R8: An overflow that occurs after the arming read and before the clearing write (including during the write cycle itself) keeps the flag set after that write.
- R9: `irq` is high exactly when the interrupt-enable bit (control bit 1) and the flag are both 1.
- R10: The register map is: 0 = control/status, 1 = counter high, 2 = counter low, 3 = modulo high, 4 = modulo low. Reading the counter high byte captures the low byte, and later reads of address 2 return that captured byte.
- R11: A write to address 1 or 2 clears the counter and the prescaler, whatever data is written, and restarts counting upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; read side effects happen at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ext_tick_a | input | 1 | Synchronous single-cycle count enable, source code 2 |
| ext_tick_b | input | 1 | Synchronous single-cycle count enable, source code 3 |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach from the ports is an overflow that lands between the arming read and the clearing write. To create it, the bench reads the status while the counter runs with a short modulo. It then waits longer than one period before writing 0, so the write meets a re-set flag. It also issues clearing writes while the counter is still running, so some of them fall on an overflow cycle, and the behavioural model decides the result. Center-aligned turnarounds are checked through `irq` on every cycle, which shows exactly which step raised the flag.

// File: rtl/modtimer_pkg.sv
package modtimer_pkg;

    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int PS_W   = 3;
    localparam int SEL_W  = 2;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_MOD_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_MOD_LO = 3'd4;

    typedef enum logic [1:0] {
        FLAG_CLEAR = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_ARMED = 2'd2
    } flag_state_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

endpackage

// File: rtl/modtimer_prescale.sv
module modtimer_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            src_tick,
    input  logic [PS_W-1:0] ps_code,
    output logic            step
);
    localparam int PRE_W = (1 << PS_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = ~({PRE_W{1'b1}} << ps_code);
        step = src_tick && ((pre_cnt & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pre_cnt <= '0;
        else if (clr)      pre_cnt <= '0;
        else if (src_tick) pre_cnt <= pre_cnt + 1'b1;
    end

    // R3
    prescale_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_tick && !clr) |=> $stable(pre_cnt));

endmodule

// File: rtl/modtimer_counter.sv
module modtimer_counter
    import modtimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             center,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    dir_e             dir_q, dir_d;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] lim;

    assign lim = (modulo == '0) ? {CNT_W{1'b1}} : modulo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
            cnt   <= '0;
        end else begin
            dir_q <= dir_d;
            cnt   <= cnt_d;
        end
    end

    always_comb begin
        dir_d = dir_q;
        cnt_d = cnt;
        ovf   = 1'b0;
        if (clr) begin
            dir_d = DIR_UP;
            cnt_d = '0;
        end else if (!center) begin
            dir_d = DIR_UP;
            if (step) begin
                if (cnt == lim) begin
                    cnt_d = '0;
                    ovf   = 1'b1;
                end else begin
                    cnt_d = cnt + 1'b1;
                end
            end
        end else if (step) begin
            unique case (dir_q)
                DIR_UP: begin
                    if (cnt == lim) begin
                        dir_d = DIR_DOWN;
                        cnt_d = cnt - 1'b1;
                        ovf   = 1'b1;
                    end else begin
                        cnt_d = cnt + 1'b1;
                    end
                end
                DIR_DOWN: begin
                    if (cnt == '0) begin
                        dir_d = DIR_UP;
                        cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
                    end else begin
                        cnt_d = cnt - 1'b1;
                    end
                end
                default: dir_d = DIR_UP;
            endcase
        end
    end

    // R11
    cnt_zero_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R2
    hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(cnt));

    // R4
    up_wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !center) |=> (cnt == '0));

    // R6
    center_turn_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && center) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/modtimer_ovf_flag.sv
module modtimer_ovf_flag
    import modtimer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic rd_status,
    input  logic wr_status,
    input  logic wr_bit,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (ovf) state_d = FLAG_SET;
            FLAG_SET: begin
                if (ovf)            state_d = FLAG_SET;
                else if (rd_status) state_d = FLAG_ARMED;
            end
            FLAG_ARMED: begin
                if (ovf)                       state_d = FLAG_SET;
                else if (wr_status && !wr_bit) state_d = FLAG_CLEAR;
            end
            default: state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q != FLAG_CLEAR);
    end

    // R7
    flag_falls_only_on_clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(wr_status && !wr_bit));

    // R8
    ovf_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag);

    // R4
    flag_rises_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(ovf));

endmodule

// File: rtl/modtimer_core.sv
module modtimer_core
    import modtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_tick_a,
    input  logic              ext_tick_b,
    output logic              irq
);
    logic [PS_W-1:0]   ps_q;
    logic [SEL_W-1:0]  sel_q;
    logic              center_q;
    logic              ien_q;
    logic [CNT_W-1:0]  mod_q;
    logic [BYTE_W-1:0] lo_snap_q;

    logic              src_tick, step, ovf, flag, cnt_clr;
    logic              rd_status, wr_status;
    logic [CNT_W-1:0]  cnt;

    assign rd_status = bus_rd && (bus_addr == A_CTRL);
    assign wr_status = bus_wr && (bus_addr == A_CTRL);
    assign cnt_clr   = bus_wr && ((bus_addr == A_CNT_HI) || (bus_addr == A_CNT_LO));

    always_comb begin
        unique case (sel_q)
            2'd0:    src_tick = 1'b0;
            2'd1:    src_tick = 1'b1;
            2'd2:    src_tick = ext_tick_a;
            default: src_tick = ext_tick_b;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q      <= '0;
            sel_q     <= '0;
            center_q  <= 1'b0;
            ien_q     <= 1'b0;
            mod_q     <= '0;
            lo_snap_q <= '0;
        end else begin
            if (wr_status) begin
                ps_q     <= bus_wdata[7:5];
                sel_q    <= bus_wdata[4:3];
                center_q <= bus_wdata[2];
                ien_q    <= bus_wdata[1];
            end
            if (bus_wr && bus_addr == A_MOD_HI) mod_q[CNT_W-1:BYTE_W] <= bus_wdata;
            if (bus_wr && bus_addr == A_MOD_LO) mod_q[BYTE_W-1:0]     <= bus_wdata;
            if (bus_rd && bus_addr == A_CNT_HI) lo_snap_q             <= cnt[BYTE_W-1:0];
        end
    end

    modtimer_prescale #(.PS_W(PS_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
        .src_tick(src_tick), .ps_code(ps_q), .step(step)
    );

    modtimer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .step(step),
        .center(center_q), .modulo(mod_q), .cnt(cnt), .ovf(ovf)
    );

    modtimer_ovf_flag u_flag (
        .clk(clk), .rst_n(rst_n), .ovf(ovf), .rd_status(rd_status),
        .wr_status(wr_status), .wr_bit(bus_wdata[0]), .flag(flag)
    );

    always_comb begin
        unique case (bus_addr)
            A_CTRL:   bus_rdata = {ps_q, sel_q, center_q, ien_q, flag};
            A_CNT_HI: bus_rdata = cnt[CNT_W-1:BYTE_W];
            A_CNT_LO: bus_rdata = lo_snap_q;
            A_MOD_HI: bus_rdata = mod_q[CNT_W-1:BYTE_W];
            A_MOD_LO: bus_rdata = mod_q[BYTE_W-1:0];
            default:  bus_rdata = '0;
        endcase
        irq = ien_q && flag;
    end

    // R1
    stopped_source_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 2'd0) |-> !step);

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && ien_q && !wr_status) |=> irq);

endmodule

// File: tb/tb_modtimer_core.sv
module tb_modtimer_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_tick_a = 1'b0, ext_tick_b = 1'b0;
    logic       irq;

    always #10 clk = ~clk;

    modtimer_core dut (.*);

    int total = 0, bad = 0;

    // behavioural reference state
    int m_cnt, m_mod, m_pres, m_ps, m_sel, m_snap;
    bit m_down, m_center, m_ien, m_flag, m_armed;

    function automatic int exp_read(int a);
        case (a)
            0: return (m_ps << 5) | (m_sel << 3) | (int'(m_center) << 2) | (int'(m_ien) << 1) | int'(m_flag);
            1: return (m_cnt >> 8) & 255;
            2: return m_snap;
            3: return (m_mod >> 8) & 255;
            4: return m_mod & 255;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mod = 0; m_pres = 0; m_ps = 0; m_sel = 0; m_snap = 0;
            m_down = 0; m_center = 0; m_ien = 0; m_flag = 0; m_armed = 0;
        end else begin
            bit src, stp, ov;
            int lim, ncnt;
            src = (m_sel == 1) || (m_sel == 2 && ext_tick_a) || (m_sel == 3 && ext_tick_b);
            stp = 0; ov = 0;
            if (src) begin
                if (m_pres % (1 << m_ps) == (1 << m_ps) - 1) stp = 1;
                m_pres = (m_pres + 1) % 128;
            end
            lim = (m_mod == 0) ? 65535 : m_mod;
            ncnt = m_cnt;
            if (!m_center) begin
                m_down = 0;
                if (stp) begin
                    if (m_cnt == lim) begin ncnt = 0; ov = 1; end
                    else ncnt = (m_cnt + 1) % 65536;
                end
            end else if (stp) begin
                if (!m_down) begin
                    if (m_cnt == lim) begin ncnt = m_cnt - 1; m_down = 1; ov = 1; end
                    else ncnt = (m_cnt + 1) % 65536;
                end else begin
                    if (m_cnt == 0) begin ncnt = 1; m_down = 0; end
                    else ncnt = m_cnt - 1;
                end
            end
            if (bus_rd && bus_addr == 1) m_snap = m_cnt & 255;
            if (ov) begin m_flag = 1; m_armed = 0; end
            else if (bus_rd && bus_addr == 0 && m_flag) m_armed = 1;
            else if (bus_wr && bus_addr == 0 && !bus_wdata[0] && m_armed) begin
                m_flag = 0; m_armed = 0;
            end
            m_cnt = ncnt;
            if (bus_wr) begin
                case (bus_addr)
                    0: begin
                        m_ps = int'(bus_wdata[7:5]); m_sel = int'(bus_wdata[4:3]);
                        m_center = bus_wdata[2]; m_ien = bus_wdata[1];
                    end
                    1, 2: begin m_cnt = 0; m_pres = 0; m_down = 0; end
                    3: m_mod = (m_mod & 255) | (int'(bus_wdata) << 8);
                    4: m_mod = (m_mod & 65280) | int'(bus_wdata);
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R9: interrupt compared with the model on every cycle
    always @(negedge clk) begin
        if (rst_n) check("R9 irq", int'(irq), int'(m_ien && m_flag));
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic rd(int a, string tag);
        @(negedge clk);
        bus_addr = 3'(a); bus_rd = 1'b1;
        #1 check(tag, int'(bus_rdata), exp_read(a));
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic tick(bit a, bit b);
        @(negedge clk);
        ext_tick_a = a; ext_tick_b = b;
        @(posedge clk); #1 ext_tick_a = 1'b0; ext_tick_b = 1'b0;
        idle(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state, clock stopped
        for (int a = 0; a < 5; a++) rd(a, "R1 reset value");
        check("R1 irq low", int'(irq), 0);
        idle(10);
        rd(1, "R1 stopped hi"); rd(2, "R1 stopped lo");
        // R4 up mode, modulo 5, bus clock
        wr(3, 0); wr(4, 5); rd(4, "R10 modulo lo");
        wr(0, 8'h0A);
        idle(3); rd(1, "R4 cnt hi"); rd(2, "R4 cnt lo");
        idle(10); rd(0, "R4 flag set");
        // R7 clear handshake
        idle(8);
        wr(0, 8'h02);                 // stop clock, write 0 without arming read
        rd(0, "R7 no-read write keeps flag");
        wr(0, 8'h03);                 // write 1: no effect
        rd(0, "R7 write one keeps flag");
        wr(0, 8'h02);
        rd(0, "R7 flag cleared");
        // R8 overflow between read and write
        wr(0, 8'h0A); idle(10);
        rd(0, "R8 armed read");
        idle(8); wr(0, 8'h0A);
        rd(0, "R8 flag still set");
        for (int i = 0; i < 6; i++) begin rd(0, "R8 arm"); wr(0, 8'h0A); end
        // R3 prescale
        wr(0, 8'h6A); wr(2, 0); idle(20);
        rd(1, "R3 div8 hi"); rd(2, "R3 div8 lo");
        wr(3, 1); wr(0, 8'hEA); wr(1, 8'hFF); idle(300);
        rd(1, "R3 div128 hi"); rd(2, "R3 div128 lo");
        // R2 external sources
        wr(0, 8'h12); wr(2, 0);
        for (int i = 0; i < 5; i++) tick(1, 0);
        for (int i = 0; i < 4; i++) tick(0, 1);
        rd(1, "R2 src a hi"); rd(2, "R2 src a lo");
        wr(0, 8'h1A);
        for (int i = 0; i < 3; i++) tick(1, 1);
        for (int i = 0; i < 4; i++) tick(1, 0);
        rd(1, "R2 src b hi"); rd(2, "R2 src b lo");
        // R6 center-aligned, modulo 4
        wr(3, 0); wr(4, 4); wr(0, 8'h06); wr(2, 0);
        wr(0, 8'h0E);
        for (int i = 0; i < 10; i++) begin rd(1, "R6 hi"); rd(2, "R6 lo"); end
        rd(0, "R6 arm"); wr(0, 8'h0E); idle(12); rd(0, "R6 flag");
        // R10 coherent read, R5 free run
        wr(4, 0); wr(0, 8'h0A); wr(1, 0); idle(300);
        rd(1, "R10 hi latch"); idle(5); rd(2, "R10 lo latched");
        rd(0, "R5 arm"); wr(0, 8'h0A); rd(0, "R5 cleared");
        idle(65300);
        rd(0, "R5 full range overflow");
        rd(1, "R5 hi"); rd(2, "R5 lo");
        // R11 counter write clears
        wr(2, 8'h55); rd(1, "R11 hi"); rd(2, "R11 lo");
        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule